// File: doc/BRIEF.md
# OUT Endpoint Receive Bank Tracker

This block keeps the receive-side books for one OUT endpoint of a USB device controller. The endpoint has one to three packet banks. Packet data lives in a FIFO outside this block. Each time the USB side finishes receiving a packet, it offers the packet's byte count on a valid/ready handshake. The tracker accepts the packet into the next free bank and records its length. A packet longer than the endpoint's programmed maximum packet size is flagged as an overflow, and its stored length saturates at that maximum.

Firmware sees three things, all about the oldest occupied bank: a received-data-ready status, the byte count and the overflow flag. When firmware has read that bank, it pulses a release. Banks fill and drain in round-robin order. The ready status therefore stays up after a release while another bank still holds a packet. An interrupt request follows the ready status when its enable is set. Endpoint reset and endpoint disable both empty every bank and clear all status.

Back-pressure on the packet interface follows these rules. `pkt_ready` is low whenever all banks are occupied, the endpoint is disabled or an endpoint reset is asserted. While `pkt_ready` is low, `pkt_valid` has no effect, and the USB side answers the host with a NAK. A packet is taken on a clock edge where both `pkt_valid` and `pkt_ready` are high. `pkt_ready` does not depend on `pkt_valid`.

Top module: `rx_bank_tracker`

## Requirements
- R1: After `rst_n` is released, with the endpoint enabled and no other stimulus, `rx_ready`, `ovf_err` and `irq` are 0, `byte_count` is 0, and `pkt_ready` is 1.
- R2: A packet accepted on an edge (`pkt_valid` and `pkt_ready` both 1) is stored in a bank, and `rx_ready` is 1 from the following cycle on.
- R3: A stored packet whose `pkt_len` is strictly greater than `max_pkt` at acceptance has its overflow bit set. `ovf_err` shows the overflow bit of the oldest occupied bank, so it changes in the same cycle as `byte_count`. For example, length 128 with a maximum of 64 gives `ovf_err`=1.
- R4: `byte_count` equals the stored length of the oldest occupied bank. That length is `pkt_len`, saturated to `max_pkt` as it was when the packet was accepted. With no bank occupied, `byte_count` is 0 and `ovf_err` is 0.
- R5: Banks are released in the order in which they were filled, so successive releases show the lengths in arrival order.
- R6: A `rel_valid` pulse frees the oldest bank. If another bank is still occupied, `rx_ready` stays 1 and `byte_count` moves to that next bank.
- R7: When all `NUM_BANKS` banks are occupied, `pkt_ready` is 0, and a `pkt_valid` leaves every output unchanged.
- R8: A `rel_valid` pulse while no bank is occupied has no effect: the next packet is still accepted into a normal empty state.
- R9: `irq` is 1 exactly when `rx_ready` is 1 and `irq_en` is 1.
- R10: An `ep_reset` pulse, or `ep_enable` held low, empties every bank and clears `rx_ready`, `ovf_err` and `byte_count` on the next edge. `pkt_ready` is 0 while either is in force.
- R11: An accept and a release on the same edge both take effect, so the occupancy is unchanged and the oldest bank advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_enable | input | 1 | Endpoint enabled; low empties and holds the tracker clear |
| ep_reset | input | 1 | Endpoint reset pulse; empties all banks |
| max_pkt | input | CNT_W | Programmed maximum packet size in bytes |
| irq_en | input | 1 | Interrupt enable for received-data-ready |
| pkt_valid | input | 1 | USB side offers a completed packet |
| pkt_ready | output | 1 | A free bank is available; low means NAK |
| pkt_len | input | CNT_W+1 | Received packet length in bytes |
| rel_valid | input | 1 | Firmware releases the oldest bank |
| rx_ready | output | 1 | At least one bank holds a packet |
| byte_count | output | CNT_W | Length of the oldest occupied bank |
| ovf_err | output | 1 | Oldest occupied bank received an oversize packet |
| irq | output | 1 | Interrupt request |

## Verification
Every length from zero to well past the maximum is sent through a single bank. This separates lengths that fit, the exact-maximum boundary, where the packet is not oversize, and oversize lengths that must saturate. Fill-to-full followed by drain shows whether bank order is kept, whether a full tracker refuses packets, and whether the ready status holds through intermediate releases. Same-edge accept-and-release, release on an empty tracker, reset and disable mid-fill, and a long random mix checked against an arithmetic queue model tell apart pointer-ordering faults, faults in the occupancy count and faults in status gating.

// File: rtl/rxbt_pkg.sv
package rxbt_pkg;

  // Width needed to index a bank (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width needed to hold a count from 0 to n inclusive.
  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rxbt_occ_ctrl.sv
module rxbt_occ_ctrl
  import rxbt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned PW = idx_w(NUM_BANKS),
  localparam int unsigned OW = cnt_w(NUM_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [OW-1:0] occ,
  output logic          full,
  output logic          empty
);

  localparam logic [PW-1:0] LAST = PW'(NUM_BANKS - 1);
  localparam logic [OW-1:0] CAP  = OW'(NUM_BANKS);

  logic do_push, do_pop;

  assign full    = (occ == CAP);
  assign empty   = (occ == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   occ <= occ + OW'(1);
        2'b01:   occ <= occ - OW'(1);
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/rxbt_len_check.sv
module rxbt_len_check #(
  parameter int unsigned CNT_W = 11
) (
  input  logic [CNT_W:0]   pkt_len,
  input  logic [CNT_W-1:0] max_pkt,
  output logic [CNT_W-1:0] sat_len,
  output logic             oversize
);

  always_comb begin
    oversize = (pkt_len > {1'b0, max_pkt});
    sat_len  = oversize ? max_pkt : pkt_len[CNT_W-1:0];
  end

endmodule

// File: rtl/rxbt_len_store.sv
module rxbt_len_store
  import rxbt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned CNT_W     = 11,
  localparam int unsigned PW = idx_w(NUM_BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic [PW-1:0]    wr_idx,
  input  logic [CNT_W-1:0] wr_len,
  input  logic             wr_ovf,
  input  logic [PW-1:0]    rd_idx,
  output logic [CNT_W-1:0] rd_len,
  output logic             rd_ovf
);

  logic [CNT_W-1:0] len_q [NUM_BANKS];
  logic             ovf_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[b] <= '0;
        ovf_q[b] <= 1'b0;
      end else if (clear) begin
        len_q[b] <= '0;
        ovf_q[b] <= 1'b0;
      end else if (we && (wr_idx == PW'(b))) begin
        len_q[b] <= wr_len;
        ovf_q[b] <= wr_ovf;
      end
    end
  end

  always_comb begin
    rd_len = '0;
    rd_ovf = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_idx == PW'(b)) begin
        rd_len = len_q[b];
        rd_ovf = ovf_q[b];
      end
    end
  end

endmodule

// File: rtl/rx_bank_tracker.sv
module rx_bank_tracker
  import rxbt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_enable,
  input  logic             ep_reset,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             irq_en,
  input  logic             pkt_valid,
  output logic             pkt_ready,
  input  logic [CNT_W:0]   pkt_len,
  input  logic             rel_valid,
  output logic             rx_ready,
  output logic [CNT_W-1:0] byte_count,
  output logic             ovf_err,
  output logic             irq
);

  localparam int unsigned PW = idx_w(NUM_BANKS);
  localparam int unsigned OW = cnt_w(NUM_BANKS);

  logic             clear, accept, release_ok;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [OW-1:0]    occ;
  logic             full, empty;
  logic [CNT_W-1:0] sat_len, head_len;
  logic             oversize, head_ovf;

  assign clear      = ep_reset || !ep_enable;
  assign pkt_ready  = !clear && !full;
  assign accept     = pkt_valid && pkt_ready;
  assign release_ok = rel_valid && !clear;

  rxbt_occ_ctrl #(.NUM_BANKS(NUM_BANKS)) u_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .push   (accept),
    .pop    (release_ok),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .occ    (occ),
    .full   (full),
    .empty  (empty)
  );

  rxbt_len_check #(.CNT_W(CNT_W)) u_chk (
    .pkt_len  (pkt_len),
    .max_pkt  (max_pkt),
    .sat_len  (sat_len),
    .oversize (oversize)
  );

  rxbt_len_store #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .we     (accept),
    .wr_idx (wr_ptr),
    .wr_len (sat_len),
    .wr_ovf (oversize),
    .rd_idx (rd_ptr),
    .rd_len (head_len),
    .rd_ovf (head_ovf)
  );

  assign rx_ready   = !empty;
  assign byte_count = empty ? '0 : head_len;
  assign ovf_err    = !empty && head_ovf;
  assign irq        = rx_ready && irq_en;

endmodule

// File: rtl/rx_bank_tracker_checker.sv
module rx_bank_tracker_checker #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned OW        = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ep_enable,
  input logic             ep_reset,
  input logic             irq_en,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic             rel_valid,
  input logic             rx_ready,
  input logic [CNT_W-1:0] byte_count,
  input logic             ovf_err,
  input logic             irq,
  input logic [OW-1:0]    occ
);

  assert_accept_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> rx_ready);

  assert_empty_shows_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (byte_count == '0 && !ovf_err));

  assert_release_keeps_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && ep_enable && !ep_reset && occ > OW'(1)) |=> rx_ready);

  assert_full_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OW'(NUM_BANKS)) |-> !pkt_ready);

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && rx_ready));

  assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && irq_en) |-> irq);

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_reset || !ep_enable) |=> (!rx_ready && !ovf_err && byte_count == '0));

  assert_clear_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_reset || !ep_enable) |-> !pkt_ready);

endmodule

bind rx_bank_tracker rx_bank_tracker_checker #(
  .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .OW(OW)
) u_checker (
  .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .ep_reset(ep_reset),
  .irq_en(irq_en), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .rel_valid(rel_valid), .rx_ready(rx_ready), .byte_count(byte_count),
  .ovf_err(ovf_err), .irq(irq), .occ(occ)
);

// File: tb/rx_bank_tracker_tb.sv
`timescale 1ns/1ps
module rx_bank_tracker_tb;

  localparam int NB = 3;
  localparam int CW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ep_enable = 1'b1, ep_reset = 1'b0, irq_en = 1'b0;
  logic [CW-1:0] max_pkt = CW'(8);
  logic          pkt_valid = 1'b0, rel_valid = 1'b0;
  logic [CW:0]   pkt_len = '0;
  logic          pkt_ready, rx_ready, ovf_err, irq;
  logic [CW-1:0] byte_count;

  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  int m_len[NB];
  bit m_ovf[NB];
  int m_head = 0, m_cnt = 0;

  always #2 clk = ~clk;

  rx_bank_tracker #(.NUM_BANKS(NB), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .ep_reset(ep_reset),
    .max_pkt(max_pkt), .irq_en(irq_en), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .rel_valid(rel_valid),
    .rx_ready(rx_ready), .byte_count(byte_count), .ovf_err(ovf_err), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input string tag);
    int e_bc;
    bit e_ovf;
    e_bc  = (m_cnt > 0) ? m_len[m_head] : 0;
    e_ovf = (m_cnt > 0) ? m_ovf[m_head] : 1'b0;
    chk(rx_ready == (m_cnt > 0), {tag, " R2 rx_ready"}, rx_ready, m_cnt > 0);
    chk(byte_count == CW'(e_bc), {tag, " R4 byte_count"}, byte_count, e_bc);
    chk(ovf_err == e_ovf, {tag, " R3 ovf_err"}, ovf_err, e_ovf);
    chk(irq == ((m_cnt > 0) && irq_en), {tag, " R9 irq"}, irq, (m_cnt > 0) && irq_en);
  endtask

  // One clock: inputs are set away from the edge, the model is advanced, outputs sampled 1ns after.
  task automatic cycle(input bit v, input int len, input bit rel, input string tag);
    bit clr, e_rdy, acc, pop;
    int mx;
    pkt_valid = v;
    pkt_len   = (CW+1)'(len);
    rel_valid = rel;
    #0.5;
    clr   = ep_reset || !ep_enable;
    e_rdy = !clr && (m_cnt < NB);
    chk(pkt_ready == e_rdy, {tag, " R7/R10 pkt_ready"}, pkt_ready, e_rdy);
    mx = int'(max_pkt);
    @(posedge clk);
    if (clr) begin
      m_cnt = 0; m_head = 0;
    end else begin
      acc = v && (m_cnt < NB);
      pop = rel && (m_cnt > 0);
      if (acc) begin
        m_len[(m_head + m_cnt) % NB] = (len > mx) ? mx : len;
        m_ovf[(m_head + m_cnt) % NB] = (len > mx);
      end
      if (pop) m_head = (m_head + 1) % NB;
      m_cnt = m_cnt + int'(acc) - int'(pop);
    end
    #1;
    pkt_valid = 1'b0; rel_valid = 1'b0;
    check_outputs(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e_before;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!rx_ready && !ovf_err && !irq && byte_count == 0, "R1 status after reset", rx_ready, 0);
    chk(pkt_ready == 1'b1, "R1 pkt_ready after reset", pkt_ready, 1);

    // R3/R4 sweep of every length around the maximum
    max_pkt = CW'(8);
    for (int l = 0; l <= 20; l++) begin
      cycle(1, l, 0, "R3 sweep push");
      chk(ovf_err == (l > 8), "R3 ovf boundary", ovf_err, l > 8);
      chk(int'(byte_count) == ((l > 8) ? 8 : l), "R4 saturation", byte_count, (l > 8) ? 8 : l);
      cycle(0, 0, 1, "R4 sweep release");
    end

    // R3 example 128 into 64
    max_pkt = CW'(64);
    cycle(1, 128, 0, "R3 example");
    chk(ovf_err == 1'b1 && byte_count == 64, "R3 128 into 64", byte_count, 64);
    cycle(0, 0, 1, "R3 drain");

    // R5/R6/R7 fill, refuse, drain in order
    irq_en = 1'b1;
    cycle(1, 10, 0, "R5 fill a");
    cycle(1, 70, 0, "R5 fill b");
    cycle(1, 30, 0, "R5 fill c");
    e_before = int'(byte_count);
    cycle(1, 5, 0, "R7 full push");
    chk(int'(byte_count) == e_before && rx_ready, "R7 unchanged when full", byte_count, e_before);
    cycle(0, 0, 1, "R6 release one");
    chk(rx_ready && byte_count == 64 && ovf_err, "R6 ready held, next bank", byte_count, 64);
    cycle(0, 0, 1, "R5 release two");
    chk(byte_count == 30, "R5 order", byte_count, 30);
    cycle(0, 0, 1, "R5 release three");
    chk(!rx_ready, "R5 drained", rx_ready, 0);

    // R8 release on empty
    cycle(0, 0, 1, "R8 empty release");
    cycle(0, 0, 1, "R8 empty release");
    cycle(1, 12, 0, "R8 push after");
    chk(rx_ready && byte_count == 12, "R8 normal state", byte_count, 12);

    // R11 simultaneous accept and release
    cycle(1, 20, 0, "R11 second");
    cycle(1, 33, 1, "R11 both");
    chk(byte_count == 20 && rx_ready, "R11 head advanced", byte_count, 20);
    cycle(0, 0, 1, "R11 drain");
    chk(byte_count == 33, "R11 new stored", byte_count, 33);

    // R9 irq gating
    irq_en = 1'b0;
    cycle(0, 0, 0, "R9 disabled");
    chk(!irq && rx_ready, "R9 masked", irq, 0);
    irq_en = 1'b1;
    cycle(0, 0, 0, "R9 enabled");
    chk(irq, "R9 raised", irq, 1);

    // R10 reset and disable
    cycle(1, 99, 0, "R10 fill");
    ep_reset = 1'b1;
    cycle(1, 4, 1, "R10 reset");
    ep_reset = 1'b0;
    chk(!rx_ready && !ovf_err && byte_count == 0, "R10 reset clears", rx_ready, 0);
    cycle(1, 7, 0, "R10 refill");
    ep_enable = 1'b0;
    cycle(1, 9, 0, "R10 disable");
    cycle(1, 9, 0, "R10 disabled hold");
    chk(!rx_ready, "R10 disable clears", rx_ready, 0);
    ep_enable = 1'b1;

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      ep_reset = (r < 2);
      ep_enable = !(r >= 2 && r < 4);
      irq_en = $urandom_range(0, 1) == 1;
      if (r == 50) max_pkt = CW'($urandom_range(1, 64));
      cycle($urandom_range(0, 2) != 0, int'($urandom_range(0, 80)),
            $urandom_range(0, 2) == 0, "R5 random");
    end
    ep_reset = 1'b0; ep_enable = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule